// File: doc/BRIEF.md
# Mode-0 SPI Master with Per-Word Frame Pulse

This block is a serial peripheral master for clock polarity 0 and phase 0, so SCK rests low. Software-side logic pushes fixed-width words into a small transmit queue. The engine shifts each word out on MOSI, most significant bit first, while it collects the same number of bits from MISO. It then places the received word into a receive queue, which the consumer drains with a pop handshake.

Every word gets its own frame. FSS drops before the first bit and rises again one SCK period after the last capture. When more words are waiting, FSS stays high with SCK parked low for a programmed number of SCK periods before the next frame opens. A slave that freezes its shift register while selected can therefore reload between words, and the gap length is guaranteed rather than left to chance.

The word width, the SCK half-period (counted in system clocks) and the gap length are inputs. Each value is sampled when a word starts, so a change takes effect from the next frame onward.

Top module: `spi_frame_master`

## Requirements
- R1: While reset is held and directly after it, FSS is high, SCK, MOSI, busy, rx_valid, tx_full and rx_overrun are low.
- R2: SCK idles low and is never high while FSS is high; MOSI changes only while SCK is low; the first rising SCK edge comes `cfg_half` clocks after FSS falls.
- R3: The effective word width is `cfg_width` clamped to 4..16. The low `width` bits of `tx_data` go out MSB first, and exactly `width` rising SCK edges occur per frame.
- R4: SCK high time equals the effective half-period `H` (where `cfg_half` = 0 counts as 1), and the rising-to-rising period is `2*H` clocks.
- R5: FSS rises `2*H` clocks after the last rising SCK edge of a word.
- R6: When another word is queued at the end of a frame, FSS stays high for exactly `G*2*H` clocks (where `cfg_gap` = 0 counts as 1) with SCK low, and then the next frame starts.
- R7: busy rises together with the first FSS fall of a burst, stays high through every inter-word gap, and falls in the same cycle that FSS rises after the final word.
- R8: tx_full is high when the transmit queue holds TX_DEPTH words. A push while full is ignored and tx_drop is high in that same cycle, combinationally from tx_push.
- R9: The received word holds the `width` MISO bits sampled on rising SCK edges, MSB first, zero-extended. It enters the receive queue in the cycle FSS rises.
- R10: A received word that finds the receive queue full is discarded, earlier words stay intact, and rx_overrun is set and stays set until reset.
- R11: rx_valid is high while the receive queue is non-empty, rx_data shows the oldest word, and rx_pop removes it (first in, first out).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half | input | HALF_W | SCK half-period in clocks (0 acts as 1) |
| cfg_width | input | 5 | Word width request, clamped to 4..16 |
| cfg_gap | input | GAP_W | Inter-word FSS high time in SCK periods (0 acts as 1) |
| tx_data | input | 16 | Word to enqueue, right-aligned |
| tx_push | input | 1 | Enqueue strobe |
| tx_full | output | 1 | Transmit queue full |
| tx_drop | output | 1 | Push rejected in this cycle |
| rx_data | output | 16 | Oldest received word |
| rx_valid | output | 1 | Receive queue non-empty |
| rx_pop | input | 1 | Dequeue strobe |
| rx_overrun | output | 1 | Sticky receive overflow flag |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| fss | output | 1 | Frame select, active low |
| busy | output | 1 | Burst in progress |

## Verification
A stuck bit counter or a mislatched width shows up in the first frame as a wrong count of SCK rising edges and a truncated or shifted MOSI word. A half-tick or gap counter that is off by one changes the measured lead, high time, tail or gap by a multiple of `H` clocks within one frame. A state machine that leaves the gap too early, or that ends a burst with a word still queued, shows up within a single burst as extra busy edges or as SCK activity while FSS is high. Receive-queue pointer faults appear at the first pop as out-of-order data, or after overflow as a lost older word.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  localparam int WORD_MAX = 16;
  localparam int WORD_MIN = 4;
  localparam int WCFG_W   = 5;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_TAIL  = 2'd2,
    ENG_GAP   = 2'd3
  } eng_state_t;

  // clamp a width request into the supported range
  function automatic logic [WCFG_W-1:0] fit_width(input logic [WCFG_W-1:0] req);
    if (req < WCFG_W'(WORD_MIN)) return WCFG_W'(WORD_MIN);
    if (req > WCFG_W'(WORD_MAX)) return WCFG_W'(WORD_MAX);
    return req;
  endfunction

  // ones in the low w bit positions
  function automatic logic [WORD_MAX-1:0] width_mask(input logic [WCFG_W-1:0] w);
    logic [WORD_MAX:0] one;
    one = (WORD_MAX+1)'(1) << w;
    return WORD_MAX'(one - (WORD_MAX+1)'(1));
  endfunction

  // move the low w bits of d to the top of the shift register
  function automatic logic [WORD_MAX-1:0] msb_align(input logic [WORD_MAX-1:0] d,
                                                     input logic [WCFG_W-1:0] w);
    return (d & width_mask(w)) << (WCFG_W'(WORD_MAX) - w);
  endfunction

endpackage

// File: rtl/spi_fm_queue.sv
module spi_fm_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign rdata   = mem[rptr];
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R11
  cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> (count == $past(count)));

endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
  import spi_fm_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int GAP_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HALF_W-1:0]   cfg_half,
  input  logic [WCFG_W-1:0]   cfg_width,
  input  logic [GAP_W-1:0]    cfg_gap,
  input  logic                tx_avail,
  input  logic [WORD_MAX-1:0] tx_word,
  output logic                tx_take,
  output logic                rx_put,
  output logic [WORD_MAX-1:0] rx_word,
  input  logic                miso,
  output logic                sck,
  output logic                mosi,
  output logic                fss,
  output logic                busy
);

  localparam int GT_W = GAP_W + 1;

  function automatic logic [HALF_W-1:0] eff_half(input logic [HALF_W-1:0] h);
    return (h == '0) ? HALF_W'(1) : h;
  endfunction

  // gap length counted in half periods
  function automatic logic [GT_W-1:0] gap_ticks(input logic [GAP_W-1:0] g);
    logic [GT_W-1:0] g1;
    g1 = (g == '0) ? GT_W'(1) : {1'b0, g};
    return g1 << 1;
  endfunction

  eng_state_t            st;
  logic [HALF_W-1:0]     hcnt, half_q;
  logic [WCFG_W-1:0]     w_q, bcnt;
  logic [GT_W-1:0]       gcnt;
  logic [WORD_MAX-1:0]   tsh, rsh;
  logic                  half_tick, gap_done, start_now, last_bit;
  logic [WCFG_W-1:0]     start_w;

  assign half_tick = (st != ENG_IDLE) && (hcnt == half_q - 1'b1);
  assign gap_done  = (st == ENG_GAP) && half_tick && (gcnt == GT_W'(1));
  assign start_now = ((st == ENG_IDLE) && tx_avail) || gap_done;
  assign start_w   = fit_width(cfg_width);
  assign last_bit  = (bcnt == w_q);
  assign tx_take   = start_now;
  assign rx_put    = (st == ENG_TAIL) && half_tick;
  assign rx_word   = rsh & width_mask(w_q);
  assign mosi      = tsh[WORD_MAX-1];
  assign busy      = (st != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ENG_IDLE;
      hcnt   <= '0;
      half_q <= HALF_W'(1);
      w_q    <= WCFG_W'(WORD_MIN);
      bcnt   <= '0;
      gcnt   <= '0;
      tsh    <= '0;
      rsh    <= '0;
      sck    <= 1'b0;
      fss    <= 1'b1;
    end else begin
      if (st == ENG_IDLE || half_tick) hcnt <= '0;
      else                             hcnt <= hcnt + 1'b1;

      if (start_now) begin
        st     <= ENG_SHIFT;
        fss    <= 1'b0;
        sck    <= 1'b0;
        half_q <= eff_half(cfg_half);
        w_q    <= start_w;
        tsh    <= msb_align(tx_word, start_w);
        rsh    <= '0;
        bcnt   <= '0;
      end else if (half_tick) begin
        case (st)
          ENG_SHIFT: begin
            if (!sck) begin
              sck  <= 1'b1;
              rsh  <= {rsh[WORD_MAX-2:0], miso};
              bcnt <= bcnt + 1'b1;
            end else begin
              sck <= 1'b0;
              if (last_bit) st <= ENG_TAIL;
              else          tsh <= {tsh[WORD_MAX-2:0], 1'b0};
            end
          end
          ENG_TAIL: begin
            fss <= 1'b1;
            tsh <= '0;
            if (tx_avail) begin
              st   <= ENG_GAP;
              gcnt <= gap_ticks(cfg_gap);
            end else begin
              st <= ENG_IDLE;
            end
          end
          ENG_GAP:  gcnt <= gcnt - 1'b1;
          default:  st <= st;
        endcase
      end
    end
  end

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fss |-> !sck);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $rose(fss));

  // R7
  busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fss |-> busy);

  // R3
  bit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= w_q);

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int HALF_W   = 8,
  parameter int GAP_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HALF_W-1:0]   cfg_half,
  input  logic [WCFG_W-1:0]   cfg_width,
  input  logic [GAP_W-1:0]    cfg_gap,
  input  logic [WORD_MAX-1:0] tx_data,
  input  logic                tx_push,
  output logic                tx_full,
  output logic                tx_drop,
  output logic [WORD_MAX-1:0] rx_data,
  output logic                rx_valid,
  input  logic                rx_pop,
  output logic                rx_overrun,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic                fss,
  output logic                busy
);

  logic                tx_empty, tx_take;
  logic [WORD_MAX-1:0] tx_head;
  logic                rx_put, rx_full, rx_empty;
  logic [WORD_MAX-1:0] rx_word;
  logic                rx_lost;

  assign tx_drop  = tx_push && tx_full;
  assign rx_valid = !rx_empty;
  assign rx_lost  = rx_put && rx_full;

  spi_fm_queue #(.W(WORD_MAX), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .wdata(tx_data), .full(tx_full),
    .pop(tx_take), .rdata(tx_head), .empty(tx_empty)
  );

  spi_fm_engine #(.HALF_W(HALF_W), .GAP_W(GAP_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .cfg_half(cfg_half), .cfg_width(cfg_width), .cfg_gap(cfg_gap),
    .tx_avail(!tx_empty), .tx_word(tx_head), .tx_take(tx_take),
    .rx_put(rx_put), .rx_word(rx_word),
    .miso(miso), .sck(sck), .mosi(mosi), .fss(fss), .busy(busy)
  );

  spi_fm_queue #(.W(WORD_MAX), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_put), .wdata(rx_word), .full(rx_full),
    .pop(rx_pop), .rdata(rx_data), .empty(rx_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       rx_overrun <= 1'b0;
    else if (rx_lost) rx_overrun <= 1'b1;
  end

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_overrun) |-> rx_overrun);

  // R9
  rx_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_put |=> $rose(fss));

endmodule

// File: tb/spi_frame_master_test.sv
module spi_frame_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_half = 8'd2;
  logic [4:0]  cfg_width = 5'd8;
  logic [3:0]  cfg_gap = 4'd1;
  logic [15:0] tx_data = '0;
  logic        tx_push = 1'b0;
  logic        rx_pop = 1'b0;
  logic        miso = 1'b0;
  wire         tx_full, tx_drop, rx_valid, rx_overrun, sck, mosi, fss, busy;
  wire  [15:0] rx_data;

  always #5 clk = ~clk;

  spi_frame_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_width(cfg_width),
    .cfg_gap(cfg_gap), .tx_data(tx_data), .tx_push(tx_push), .tx_full(tx_full),
    .tx_drop(tx_drop), .rx_data(rx_data), .rx_valid(rx_valid), .rx_pop(rx_pop),
    .rx_overrun(rx_overrun), .sck(sck), .mosi(mosi), .miso(miso), .fss(fss),
    .busy(busy)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] bmask(input int w);
    return 16'((32'd1 << w) - 1);
  endfunction

  function automatic int bwidth(input int req);
    return (req < 4) ? 4 : (req > 16) ? 16 : req;
  endfunction

  function automatic logic [15:0] slave_word(input logic [15:0] base, input int f);
    return base ^ (16'(f) * 16'h2B71);
  endfunction

  // monitor state, written only by the monitor process
  logic        mon_clr = 1'b0;
  logic [15:0] sbase = 16'h9C35;
  int          cur_w = 8;
  int cyc = 0, nfr = 0, busy_rises = 0, busy_fall = 0, mosi_bad = 0, sck_gap_bad = 0;
  int fall_cyc = 0, rise_cyc = 0, last_rise = 0, bits = 0, sidx = 0;
  bit first = 1'b0;
  logic [15:0] acc = '0, cur_sw = '0;
  logic prev_sck = 1'b0, prev_fss = 1'b1, prev_mosi = 1'b0, prev_busy = 1'b0;
  int   fr_lead[8], fr_per[8], fr_hi[8], fr_tail[8], fr_bits[8], fr_gap[8];
  logic [15:0] fr_word[8];

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      nfr = 0; busy_rises = 0; mosi_bad = 0; sck_gap_bad = 0;
    end else begin
      if (prev_fss && !fss) begin
        fall_cyc = cyc; acc = '0; bits = 0; first = 1'b1;
        if (nfr > 0) fr_gap[nfr % 8] = cyc - rise_cyc;
        cur_sw = slave_word(sbase, nfr);
        sidx = cur_w - 1;
        miso = cur_sw[sidx];
      end
      if (!prev_sck && sck) begin
        acc = {acc[14:0], mosi};
        bits++;
        if (first) fr_lead[nfr % 8] = cyc - fall_cyc;
        else       fr_per[nfr % 8] = cyc - last_rise;
        first = 1'b0;
        last_rise = cyc;
      end
      if (prev_sck && !sck) begin
        fr_hi[nfr % 8] = cyc - last_rise;
        if (sidx > 0) sidx--;
        miso = cur_sw[sidx];
      end
      if (!prev_fss && fss) begin
        fr_word[nfr % 8] = acc;
        fr_bits[nfr % 8] = bits;
        fr_tail[nfr % 8] = cyc - last_rise;
        rise_cyc = cyc;
        nfr++;
      end
      if (fss && sck) sck_gap_bad++;
      if (sck && prev_sck && (mosi != prev_mosi)) mosi_bad++;
      if (!prev_busy && busy) busy_rises++;
      if (prev_busy && !busy) busy_fall = cyc;
    end
    prev_sck = sck; prev_fss = fss; prev_mosi = mosi; prev_busy = busy;
  end

  task automatic mon_reset(input logic [15:0] base, input int w);
    sbase = base;
    cur_w = bwidth(w);
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic push_word(input logic [15:0] d);
    @(negedge clk);
    tx_data = d; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    do @(negedge clk); while (!(nfr >= n && !busy));
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_expect(input string req, input logic [15:0] exp);
    @(negedge clk);
    chk(req, int'(rx_valid), 1);
    chk(req, int'(rx_data), int'(exp));
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 fss", int'(fss), 1);
    chk("R1 sck", int'(sck), 0);
    chk("R1 busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mosi", int'(mosi), 0);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 tx_full", int'(tx_full), 0);
    chk("R1 overrun", int'(rx_overrun), 0);
  endtask

  task automatic t_single();
    int h;
    h = 2;
    cfg_half = 8'(h); cfg_width = 5'd8; cfg_gap = 4'd1;
    mon_reset(16'h9C35, 8);
    push_word(16'h5AC3);
    wait_frames(1);
    chk("R3 frames", nfr, 1);
    chk("R3 bits", fr_bits[0], 8);
    chk("R3 word", int'(fr_word[0]), 16'hC3);
    chk("R2 lead", fr_lead[0], h);
    chk("R4 period", fr_per[0], 2 * h);
    chk("R4 high", fr_hi[0], h);
    chk("R5 tail", fr_tail[0], 2 * h);
    chk("R7 busy rises", busy_rises, 1);
    chk("R7 busy fall", busy_fall, rise_cyc);
    chk("R2 mosi stable", mosi_bad, 0);
    pop_expect("R9 rx word", slave_word(16'h9C35, 0) & bmask(8));
    @(negedge clk);
    chk("R11 empty", int'(rx_valid), 0);
  endtask

  task automatic t_width(input int req, input int h, input logic [15:0] d);
    int w;
    w = bwidth(req);
    cfg_half = 8'(h); cfg_width = 5'(req);
    mon_reset(16'h36E1 ^ 16'(req), req);
    push_word(d);
    wait_frames(1);
    chk("R3 clamp bits", fr_bits[0], w);
    chk("R3 clamp word", int'(fr_word[0]), int'(d & bmask(w)));
    chk("R4 period", fr_per[0], 2 * h);
    chk("R5 tail", fr_tail[0], 2 * h);
    pop_expect("R9 rx word", slave_word(16'h36E1 ^ 16'(req), 0) & bmask(w));
  endtask

  task automatic t_burst();
    int h, g;
    h = 2; g = 3;
    cfg_half = 8'(h); cfg_width = 5'd12; cfg_gap = 4'(g);
    mon_reset(16'h71D4, 12);
    push_word(16'hA123);
    push_word(16'h0B45);
    push_word(16'hFC67);
    wait_frames(3);
    chk("R6 frames", nfr, 3);
    chk("R6 gap1", fr_gap[1], g * 2 * h);
    chk("R6 gap2", fr_gap[2], g * 2 * h);
    chk("R6 sck idle in gap", sck_gap_bad, 0);
    chk("R7 single busy", busy_rises, 1);
    chk("R7 busy end", busy_fall, rise_cyc);
    chk("R3 w0", int'(fr_word[0]), 16'h123);
    chk("R3 w1", int'(fr_word[1]), 16'hB45);
    chk("R3 w2", int'(fr_word[2]), 16'hC67);
    for (int i = 0; i < 3; i++)
      pop_expect("R11 fifo order", slave_word(16'h71D4, i) & bmask(12));
  endtask

  task automatic t_zero_cfg();
    cfg_half = 8'd0; cfg_width = 5'd8; cfg_gap = 4'd0;
    mon_reset(16'h4B2E, 8);
    push_word(16'h00E7);
    push_word(16'h0018);
    wait_frames(2);
    chk("R6 min gap", fr_gap[1], 2);
    chk("R4 min period", fr_per[1], 2);
    chk("R2 min lead", fr_lead[0], 1);
    chk("R5 min tail", fr_tail[1], 2);
    chk("R3 w1", int'(fr_word[1]), 16'h18);
    pop_expect("R9 rx0", slave_word(16'h4B2E, 0) & bmask(8));
    pop_expect("R9 rx1", slave_word(16'h4B2E, 1) & bmask(8));
  endtask

  task automatic t_fill();
    cfg_half = 8'd1; cfg_width = 5'd4; cfg_gap = 4'd1;
    mon_reset(16'hD00B, 4);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      tx_data = 16'(i + 1); tx_push = 1'b1;
      #1;
      chk("R8 accepted push", int'(tx_drop), 0);
    end
    @(negedge clk);
    tx_data = 16'h0009; tx_push = 1'b1;
    #1;
    chk("R8 full", int'(tx_full), 1);
    chk("R8 drop", int'(tx_drop), 1);
    @(negedge clk);
    tx_push = 1'b0;
    wait_frames(5);
    repeat (20) @(negedge clk);
    chk("R8 frames sent", nfr, 5);
    for (int i = 0; i < 5; i++) chk("R8 sent word", int'(fr_word[i]), i + 1);
    chk("R10 overrun", int'(rx_overrun), 1);
    for (int i = 0; i < 4; i++)
      pop_expect("R10 kept word", slave_word(16'hD00B, i) & bmask(4));
    @(negedge clk);
    chk("R10 newest lost", int'(rx_valid), 0);
    chk("R10 sticky", int'(rx_overrun), 1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_width(4, 1, 16'h123A);
    t_width(20, 3, 16'hBEEF);
    t_width(2, 1, 16'h7775);
    t_burst();
    t_zero_cfg();
    t_fill();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL R7 watchdog: actual=hung expected=idle");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule